// File: doc/BRIEF.md
# Serial Configuration Programming Sequencer

This block is the host-side master for a small three-wire serial port used to program or read back a one-byte configuration store in a target device. A request is posted with a one-cycle start strobe. The request carries a read/write select, an 8-bit command byte and, for writes, an 8-bit data byte. The sequencer then produces the serial clock, the active-low enable and the serial data line towards the target. On reads it samples the data returned by the target. Every transfer uses the low-to-high edge of the serial clock as the capturing edge, and bytes travel least significant bit first.

A write sends the command byte and then the data byte, one bit per clock pulse. It then forces the data line low and holds the clock low for a long programming delay. A final dedicated clock pulse commits the byte, and the enable is released. A read sends the command byte and then gives 8 further pulses, capturing one returned bit at each pulse. The half-period of the serial clock comes from a host input, counted in system clocks and latched at start. The programming delay comes from parameters that give the system clock frequency and the delay in microseconds.

The host side is plain strobe/status, not valid/ready. `busy` stands for "not ready", and a start strobe seen while `busy` is high is dropped rather than stalled. The result is not back-pressured: `rd_byte` stays valid from the `done` pulse until the next read completes.

Top module: `serprog_master`

## Requirements
- R1: While reset is asserted and afterwards until a start is accepted, `prog_sclk`=0, `prog_en_n`=1, `prog_sdi`=0, `busy`=0 and `done`=0.
- R2: `prog_en_n` falls only while `prog_sclk` is low, and `prog_sclk` is high only while `prog_en_n` is low.
- R3: Each `prog_sdi` bit is present at least one system clock before the rising edge of `prog_sclk` that captures it, and it stays stable while the clock is high. The first 8 rising edges carry `cmd_byte` bit 0 up to bit 7. On a write, rising edges 9 to 16 carry `wr_byte` bit 0 up to bit 7.
- R4: A read (`rw_rd`=1) gives exactly 16 rising edges, with `prog_sdi` held low during edges 9 to 16. `prog_sdo` is sampled at edges 9 to 16 into `rd_byte` bits 0 to 7 in that order. `rd_byte` is valid when `done` pulses.
- R5: A write (`rw_rd`=0) gives exactly 17 rising edges. Between edge 16 and edge 17, `prog_sclk` and `prog_sdi` stay low for at least HOLD_US microseconds, which is (CLK_HZ/1e6)*HOLD_US system clocks. `prog_sdi` is low at edge 17.
- R6: Every high phase of `prog_sclk` lasts exactly max(`half_cycles`,1) system clocks. Each low phase before a data edge lasts the same number of clocks.
- R7: `busy` is high from the cycle after an accepted start until the end of the transaction. `done` is a single-cycle pulse, given together with `busy` going low and `prog_en_n` going high. No further clock edges follow it.
- R8: A start strobe while `busy` is high is ignored. The running transaction's bit sequence is unchanged, and no second transaction follows.
- R9: `half_cycles`, `rw_rd`, `cmd_byte` and `wr_byte` are latched at the accepted start. Changes to them during a transaction have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, accepted when idle |
| rw_rd | input | 1 | 1 = read transaction, 0 = write transaction |
| cmd_byte | input | 8 | Command byte sent first |
| wr_byte | input | 8 | Data byte sent on a write |
| half_cycles | input | DIV_W | Serial clock half-period in system clocks (0 treated as 1) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rd_byte | output | 8 | Byte assembled from the last read |
| prog_sclk | output | 1 | Serial clock to the target, rising edge active |
| prog_en_n | output | 1 | Active-low programming enable to the target |
| prog_sdi | output | 1 | Serial data to the target |
| prog_sdo | input | 1 | Serial data from the target |

## Verification
A wrong state in the sequencer shows at the pins within one serial clock period. A bit counter that is off by one moves every later bit to the wrong edge and changes the count of rising edges (16 or 17). A shift register that is mis-loaded shows up at the first rising edge as a wrong command bit. A wrong divider count changes the width of the next high phase. A hold counter that is short shows up only at the commit edge, as a low stretch below the programming delay. A broken capture path shows up only in `rd_byte` at `done`, so every read compares the full returned byte against the byte the target model drove.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int BYTE_W = 8;
  localparam int FRAME_BITS = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_HOLD,
    ST_COMMIT
  } seq_state_t;
endpackage

// File: rtl/serprog_tick.sv
module serprog_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = half - DIV_W'(1);
  assign tick = run && !clr && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || clr || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R6: the phase counter never passes the latched half-period
  p_phase_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (half != '0) |-> (cnt < half));
endmodule

// File: rtl/serprog_hold.sv
module serprog_hold #(
  parameter int HOLD_CYC = 1250000,
  localparam int HW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  logic [HW-1:0] cnt;
  logic          active;

  assign expired = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= HW'(HOLD_CYC - 1);
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - HW'(1);
    end
  end

  // R5: the delay ends once per load
  p_expire_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);
endmodule

// File: rtl/serprog_shift.sv
module serprog_shift
  import serprog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              is_read,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              adv,
  input  logic              cap,
  input  logic              sdo,
  output logic              cur_bit,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [FRAME_BITS-1:0] tx;
  logic [BYTE_W-1:0]     rx;

  assign cur_bit = tx[0];
  assign rx_byte = rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0;
    end else if (load) begin
      tx <= {(is_read ? {BYTE_W{1'b0}} : wdata), cmd};
    end else if (adv) begin
      tx <= {1'b0, tx[FRAME_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx <= '0;
    end else if (load) begin
      rx <= '0;
    end else if (cap) begin
      rx <= {sdo, rx[BYTE_W-1:1]};
    end
  end

  // R3: the bit on the line changes only at a bit boundary or a reload
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(tx));
endmodule

// File: rtl/serprog_master.sv
module serprog_master
  import serprog_pkg::*;
#(
  parameter int CLK_HZ  = 125000000,
  parameter int HOLD_US = 10000,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rw_rd,
  input  logic [7:0]       cmd_byte,
  input  logic [7:0]       wr_byte,
  input  logic [DIV_W-1:0] half_cycles,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rd_byte,
  output logic             prog_sclk,
  output logic             prog_en_n,
  output logic             prog_sdi,
  input  logic             prog_sdo
);
  localparam int HOLD_RAW = (CLK_HZ / 1000000) * HOLD_US;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int CNT_W    = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FIRST_RSP = CNT_W'(BYTE_W);

  seq_state_t        state;
  logic [CNT_W-1:0]  bitcnt;
  logic              rw_q;
  logic [DIV_W-1:0]  half_q;
  logic              sclk_q, en_n_q, busy_q, done_q;
  logic [7:0]        rd_q;

  logic accept, tick, run, hold_load, hold_exp, adv, cap, cur_bit;
  logic [7:0] rx_byte;

  assign accept    = (state == ST_IDLE) && start;
  assign run       = (state == ST_LO) || (state == ST_HI) || (state == ST_COMMIT);
  assign hold_load = (state == ST_HI) && tick && (bitcnt == LAST_BIT) && !rw_q;
  assign adv       = (state == ST_HI) && tick && (bitcnt != LAST_BIT);
  assign cap       = (state == ST_LO) && tick && rw_q && (bitcnt >= FIRST_RSP);

  serprog_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .clr  (accept),
    .half (half_q),
    .tick (tick)
  );

  serprog_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hold_load),
    .expired(hold_exp)
  );

  serprog_shift u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .is_read(rw_rd),
    .cmd    (cmd_byte),
    .wdata  (wr_byte),
    .adv    (adv),
    .cap    (cap),
    .sdo    (prog_sdo),
    .cur_bit(cur_bit),
    .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      rw_q   <= 1'b0;
      half_q <= DIV_W'(1);
      sclk_q <= 1'b0;
      en_n_q <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            rw_q   <= rw_rd;
            half_q <= (half_cycles == '0) ? DIV_W'(1) : half_cycles;
            bitcnt <= '0;
            en_n_q <= 1'b0;
            busy_q <= 1'b1;
            state  <= ST_LO;
          end
        end
        ST_LO: begin
          if (tick) begin
            sclk_q <= 1'b1;
            state  <= ST_HI;
          end
        end
        ST_HI: begin
          if (tick) begin
            sclk_q <= 1'b0;
            if (bitcnt != LAST_BIT) begin
              bitcnt <= bitcnt + CNT_W'(1);
              state  <= ST_LO;
            end else if (rw_q) begin
              rd_q   <= rx_byte;
              en_n_q <= 1'b1;
              busy_q <= 1'b0;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state  <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (hold_exp) begin
            sclk_q <= 1'b1;
            state  <= ST_COMMIT;
          end
        end
        ST_COMMIT: begin
          if (tick) begin
            sclk_q <= 1'b0;
            en_n_q <= 1'b1;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign prog_sclk = sclk_q;
  assign prog_en_n = en_n_q;
  assign prog_sdi  = ((state == ST_LO) || (state == ST_HI)) && cur_bit;
  assign busy      = busy_q;
  assign done      = done_q;
  assign rd_byte   = rd_q;

  // R2: enable asserted only with the clock low
  p_enable_clk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_en_n) |-> !prog_sclk);
  // R2: a high clock only inside an enabled window
  p_clk_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_sclk |-> !prog_en_n);
  // R3: data steady across a high phase
  p_sdi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_sclk && $past(prog_sclk)) |-> $stable(prog_sdi));
  // R5: clock held low through the programming delay
  p_hold_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !prog_sclk);
  // R7: done is a single pulse that ends the window
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && prog_en_n && !prog_sclk));
  // R8 / R9: a strobe during a transaction does not touch latched settings
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != ST_IDLE) && start) |=> ($stable(rw_q) && $stable(half_q)));
endmodule

// File: tb/serprog_master_bench.sv
module serprog_master_bench;
  localparam int CLK_HZ   = 125000000;
  localparam int HOLD_US  = 2;
  localparam int HOLD_CYC = (CLK_HZ / 1000000) * HOLD_US;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       rw_rd = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [7:0] wr_byte = '0;
  logic [7:0] half_cycles = 8'd1;
  logic       busy, done, prog_sclk, prog_en_n, prog_sdi;
  logic       prog_sdo = 1'b0;
  logic [7:0] rd_byte;

  always #4 clk = ~clk;

  serprog_master #(.CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US), .DIV_W(8)) u_serprog_master (
    .clk(clk), .rst_n(rst_n), .start(start), .rw_rd(rw_rd),
    .cmd_byte(cmd_byte), .wr_byte(wr_byte), .half_cycles(half_cycles),
    .busy(busy), .done(done), .rd_byte(rd_byte),
    .prog_sclk(prog_sclk), .prog_en_n(prog_en_n), .prog_sdi(prog_sdi),
    .prog_sdo(prog_sdo)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // target model and pin monitor
  int          cur_half = 1;
  logic [7:0]  tgt_byte = '0;
  int          rises = 0, hi_len = 0, lo_len = 0, hold_len = 0;
  int          width_err = 0, order_err = 0, setup_err = 0, stable_err = 0;
  logic [16:0] seen = '0;
  logic        psclk = 1'b0, pen = 1'b1, psdi = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pen && !prog_en_n) begin
        rises = 0; seen = '0; hold_len = 0; hi_len = 0;
        if (prog_sclk) order_err++;
      end
      if (prog_sclk && prog_en_n) order_err++;
      if (prog_sclk && !psclk) begin
        if (prog_sdi !== psdi) setup_err++;
        if (rises < 17) seen[rises] = prog_sdi;
        if (rises == 16) hold_len = lo_len;
        rises++;
        hi_len = 1; lo_len = 0;
      end else if (prog_sclk) begin
        hi_len++;
        if (prog_sdi !== psdi) stable_err++;
      end else if (psclk) begin
        if (hi_len != cur_half) width_err++;
        lo_len = 1;
      end else begin
        lo_len++;
      end
      prog_sdo = (rises >= 8 && rises < 16) ? tgt_byte[rises-8] : 1'b0;
      psclk = prog_sclk; pen = prog_en_n; psdi = prog_sdi;
    end
  end

  function automatic logic [16:0] exp_frame(input logic rd, input logic [7:0] c, input logic [7:0] w);
    return {1'b0, (rd ? 8'h00 : w), c};
  endfunction

  function automatic int exp_rises(input logic rd);
    return rd ? 16 : 17;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic rd, input logic [7:0] c, input logic [7:0] w,
                         input logic [7:0] r, input int h, input bit poke, input bit chg);
    int cyc;
    int r_after;
    logic [16:0] ef;
    @(negedge clk);
    rw_rd = rd; cmd_byte = c; wr_byte = w; tgt_byte = r;
    half_cycles = 8'(h); cur_half = (h == 0) ? 1 : h;
    width_err = 0; order_err = 0; setup_err = 0; stable_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7", "busy after start", int'(busy), 1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 7) begin
        start = 1'b1; cmd_byte = ~c; wr_byte = ~w; rw_rd = ~rd;
      end else begin
        start = 1'b0;
      end
      if (chg && cyc == 9) half_cycles = 8'(h + 3);
    end
    chk(cyc < 20000, "R7", "done reached", cyc, 0);
    chk(busy === 1'b0 && prog_en_n === 1'b1, "R7", "idle at done", int'({busy, prog_en_n}), 1);
    ef = exp_frame(rd, c, w);
    chk(rises == exp_rises(rd), rd ? "R4" : "R5", "rising edge count", rises, exp_rises(rd));
    chk(seen[7:0] == ef[7:0], "R3", "command bits", int'(seen[7:0]), int'(ef[7:0]));
    if (rd) begin
      chk(seen[15:8] == 8'h00, "R4", "sdi low in response", int'(seen[15:8]), 0);
      chk(rd_byte == r, "R4", "read byte", int'(rd_byte), int'(r));
    end else begin
      chk(seen[15:8] == w, "R3", "write data bits", int'(seen[15:8]), int'(w));
      chk(hold_len >= HOLD_CYC, "R5", "hold low length", hold_len, HOLD_CYC);
      chk(seen[16] == 1'b0, "R5", "sdi at commit", int'(seen[16]), 0);
    end
    chk(width_err == 0, chg ? "R9" : "R6", "high phase widths", width_err, 0);
    chk(order_err == 0, "R2", "clock/enable order", order_err, 0);
    chk(setup_err == 0 && stable_err == 0, "R3", "sdi setup/stability", setup_err + stable_err, 0);
    if (poke) chk(width_err == 0 && seen[7:0] == ef[7:0], "R8", "busy start ignored", int'(seen[7:0]), int'(ef[7:0]));
    @(negedge clk);
    chk(done === 1'b0, "R7", "done single pulse", int'(done), 0);
    r_after = rises;
    repeat (12) @(negedge clk);
    chk(prog_en_n === 1'b1 && rises == r_after && busy === 1'b0, "R8", "no follow-on transaction",
        rises, r_after);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(prog_sclk === 1'b0 && prog_en_n === 1'b1 && prog_sdi === 1'b0 && busy === 1'b0 && done === 1'b0,
        "R1", "reset outputs", int'({prog_sclk, prog_en_n, prog_sdi, busy, done}), 5'b01000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(prog_sclk === 1'b0 && prog_en_n === 1'b1 && busy === 1'b0, "R1", "idle after reset",
        int'({prog_sclk, prog_en_n, busy}), 3'b010);

    run_txn(1'b0, 8'h12, 8'h19, 8'h00, 2, 1'b0, 1'b0);
    run_txn(1'b1, 8'h11, 8'h00, 8'hA5, 1, 1'b0, 1'b0);
    run_txn(1'b0, 8'h22, 8'hFF, 8'h00, 0, 1'b0, 1'b0);
    run_txn(1'b1, 8'h21, 8'h3C, 8'h80, 3, 1'b1, 1'b0);
    run_txn(1'b0, 8'h12, 8'h01, 8'h00, 1, 1'b1, 1'b1);
    run_txn(1'b1, 8'h11, 8'h00, 8'h01, 2, 1'b0, 1'b1);

    void'($urandom(32'd20240611));
    for (int i = 0; i < 24; i++) begin
      logic       rd;
      logic [7:0] c, w, r;
      int         h;
      rd = 1'($urandom);
      c  = 8'($urandom);
      w  = 8'($urandom);
      r  = 8'($urandom);
      h  = int'($urandom % 5);
      run_txn(rd, c, w, r, h, (($urandom % 4) == 0), (($urandom % 4) == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule